// File: doc/BRIEF.md
# Single-Cycle Processor Core

This block is a compact processor core that completes one instruction on every clock edge. It fetches a 32-bit word from a small instruction store, decodes the top six bits into a set of datapath controls, reads up to two operands from a 32-entry register file, and computes a sum or difference. In the same cycle it either writes a result back, writes a data word to memory, or redirects the program counter. Five operations are understood: register add and subtract (selected by a function code), word load, word store, branch when two registers are equal, and an absolute jump within the current 256 MB region.

Both memories sit inside the top level. Before a program runs, a side port with a shared address fills them one word at a time while `run` is held low. Raising `run` lets the core execute. Lowering it freezes the program counter and blocks every state write. The current PC, the fetched word, the pending register write and the pending memory write are all brought out, so the core can be observed cycle by cycle. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `sc_core`

## Requirements
- R1: While reset is asserted the PC reads 0. While `run` is low, the PC keeps its value and neither `wb_en_o` nor `dm_we_o` is asserted.
- R2: For an instruction that is neither a branch (opcode 0x04) nor a jump (opcode 0x02), the next PC is PC+4. The PC is always word aligned.
- R3: Opcode 0x00 is the register-register format: rs in bits 25-21, rt in bits 20-16, rd in bits 15-11 and the function code in bits 5-0. Function 0x20 writes rs+rt to rd and function 0x22 writes rs-rt to rd. Any other function code writes nothing.
- R4: Opcode 0x23 loads the word at address rs plus the sign-extended bits 15-0 and writes it to the register named by bits 20-16.
- R5: Opcode 0x2B writes register rt to the data word at address rs plus the sign-extended bits 15-0. The value written is visible to a load in the following cycle.
- R6: Opcode 0x04 compares rs and rt by subtraction. When they are equal the next PC is PC+4+(sign-extended bits 15-0 shifted left by 2); otherwise it is PC+4.
- R7: Opcode 0x02 sets the next PC to bits 31-28 of PC+4, followed by bits 25-0 of the instruction, followed by two zero bits.
- R8: Register 0 always reads as zero. A write aimed at register 0 is dropped and `wb_en_o` stays low.
- R9: Any opcode other than 0x00, 0x02, 0x04, 0x23 and 0x2B performs no register or memory write, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state is written on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute enable; low holds the core |
| pl_imem_we | input | 1 | Preload write strobe for the instruction store |
| pl_dmem_we | input | 1 | Preload write strobe for the data store |
| pl_addr | input | MEM_AW | Word index used by the preload port |
| pl_wdata | input | 32 | Preload write data |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at `pc_o` |
| wb_en_o | output | 1 | A register write happens at the next edge |
| wb_addr_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written back |
| dm_we_o | output | 1 | A data memory write happens at the next edge |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Data being stored |

## Verification
On every cycle the assertions check the PC-update rules that follow from the fetched word alone: the hold while `run` is low, sequential advance, the jump target and alignment. They also check that register 0 never receives a write, that only a store raises the memory strobe, and that unknown opcodes stay silent. Values produced by arithmetic, load data, sign extension of negative offsets, the taken-or-not outcome of a branch, and memory contents written by a store and read back later depend on register and memory state. Only the bench's scripted program, with its scoreboard of expected write-backs and PCs, can show those.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluop_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_fn_e;

  typedef struct packed {
    logic   reg_dst;
    logic   alu_src;
    logic   mem_to_reg;
    logic   reg_write;
    logic   mem_read;
    logic   mem_write;
    logic   branch;
    logic   jump;
    aluop_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn,
  output logic       fn_ok
);
  // main decoder: opcode is its only input
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = AOP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.reg_dst   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_op    = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = AOP_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;  // R9: every write enable stays low
    endcase
  end

  // ALU decoder
  always_comb begin
    alu_fn = ALU_ADD;
    fn_ok  = 1'b1;
    case (ctrl.alu_op)
      AOP_SUB: alu_fn = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  alu_fn = ALU_ADD;
          FN_SUB:  alu_fn = ALU_SUB;
          default: fn_ok  = 1'b0;  // R3: unknown function writes nothing
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    if (fn == ALU_SUB) y = a - b;
    else               y = a + b;
    zero = (y == '0);
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] regs [DEPTH];

  // entry 0 is never stored (R8)
  always_ff @(posedge clk) begin
    for (int i = 1; i < DEPTH; i++) begin
      if (we && (waddr == AW'(i))) regs[i] <= wdata;
    end
  end

  always_comb begin
    rd1 = (ra1 == '0) ? '0 : regs[ra1];
    rd2 = (ra2 == '0) ? '0 : regs[ra2];
  end
endmodule

// File: rtl/sc_pcunit.sv
module sc_pcunit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] imm_sext,
  input  logic [25:0]  jidx,
  input  logic         branch,
  input  logic         zero,
  input  logic         jump,
  output logic [W-1:0] pc
);
  logic [W-1:0] pc_plus4;
  logic [W-1:0] br_target;
  logic [W-1:0] j_target;
  logic [W-1:0] pc_next;

  always_comb begin
    pc_plus4  = pc + W'(4);
    br_target = pc_plus4 + {imm_sext[W-3:0], 2'b00};
    j_target  = {pc_plus4[W-1:W-4], jidx, 2'b00};
    if (jump)                 pc_next = j_target;
    else if (branch && zero)  pc_next = br_target;
    else                      pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pc <= '0;
    else if (en) pc <= pc_next;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pl_imem_we,
  input  logic              pl_dmem_we,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [31:0]       pl_wdata,
  output logic [31:0]       pc_o,
  output logic [31:0]       instr_o,
  output logic              wb_en_o,
  output logic [4:0]        wb_addr_o,
  output logic [31:0]       wb_data_o,
  output logic              dm_we_o,
  output logic [31:0]       dm_addr_o,
  output logic [31:0]       dm_wdata_o
);
  localparam int WORDS = 2 ** MEM_AW;

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [XLEN-1:0]   pc;
  logic [XLEN-1:0]   instr;
  logic [XLEN-1:0]   imem [WORDS];
  logic [XLEN-1:0]   dmem [WORDS];
  ctrl_t             ctrl;
  alu_fn_e           alu_fn;
  logic              fn_ok;
  logic [XLEN-1:0]   rs_val, rt_val;
  logic [XLEN-1:0]   imm_sext;
  logic [XLEN-1:0]   alu_b, alu_y;
  logic              alu_zero;
  logic [REG_AW-1:0] wr_addr;
  logic [XLEN-1:0]   wr_data;
  logic [XLEN-1:0]   ld_data;
  logic              wr_en;
  logic              st_en;
  logic [MEM_AW-1:0] dm_idx;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // instruction store with preload port
  always_ff @(posedge clk) begin
    if (pl_imem_we) imem[pl_addr] <= pl_wdata;
  end
  assign instr = imem[pc[MEM_AW+1:2]];

  sc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .alu_fn (alu_fn),
    .fn_ok  (fn_ok)
  );

  sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .ra1   (instr[25:21]),
    .ra2   (instr[20:16]),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  always_comb begin
    imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    alu_b    = ctrl.alu_src ? imm_sext : rt_val;
    wr_addr  = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  end

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store
  assign dm_idx  = alu_y[MEM_AW+1:2];
  assign ld_data = ctrl.mem_read ? dmem[dm_idx] : '0;
  assign st_en   = run & ctrl.mem_write;

  always_ff @(posedge clk) begin
    if (pl_dmem_we)  dmem[pl_addr] <= pl_wdata;
    else if (st_en)  dmem[dm_idx]  <= rt_val;
  end

  always_comb begin
    wr_data = ctrl.mem_to_reg ? ld_data : alu_y;
    wr_en   = run & ctrl.reg_write & fn_ok & (wr_addr != '0);
  end

  sc_pcunit #(.W(XLEN)) u_pc (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .en       (run),
    .imm_sext (imm_sext),
    .jidx     (instr[25:0]),
    .branch   (ctrl.branch),
    .zero     (alu_zero),
    .jump     (ctrl.jump),
    .pc       (pc)
  );

  assign pc_o       = pc;
  assign instr_o    = instr;
  assign wb_en_o    = wr_en;
  assign wb_addr_o  = wr_addr;
  assign wb_data_o  = wr_data;
  assign dm_we_o    = st_en;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wb_en,
  input logic [4:0]  wb_addr,
  input logic        dm_we
);
  logic [5:0]  op;
  logic [31:0] pc4;
  logic        op_known;

  assign op       = instr[31:26];
  assign pc4      = pc + 32'd4;
  assign op_known = (op == 6'h00) || (op == 6'h02) || (op == 6'h04) ||
                    (op == 6'h23) || (op == 6'h2B);

  assert_hold_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc == $past(pc));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!wb_en && !dm_we));

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op != 6'h04 && op != 6'h02) |=> pc == $past(pc) + 32'd4);

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> op == 6'h2B);

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'h02) |=> pc == {$past(pc4[31:28]), $past(instr[25:0]), 2'b00});

  assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_addr != 5'd0);

  assert_bad_op_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !op_known) |-> (!wb_en && !dm_we));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .run     (run),
  .pc      (pc_o),
  .instr   (instr_o),
  .wb_en   (wb_en_o),
  .wb_addr (wb_addr_o),
  .dm_we   (dm_we_o)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
  localparam int MEM_AW = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              run;
  logic              pl_imem_we, pl_dmem_we;
  logic [MEM_AW-1:0] pl_addr;
  logic [31:0]       pl_wdata;
  logic [31:0]       pc_o, instr_o, wb_data_o, dm_addr_o, dm_wdata_o;
  logic              wb_en_o, dm_we_o;
  logic [4:0]        wb_addr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_on   = 1'b0;

  typedef struct {
    logic [31:0] pc;
    string       pc_req;
    logic        wb_en;
    logic [4:0]  wb_addr;
    logic [31:0] wb_data;
    logic        dm_we;
    logic [31:0] dm_addr;
    logic [31:0] dm_data;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  sc_core #(.MEM_AW(MEM_AW)) dut (
    .clk, .rst_n, .run, .pl_imem_we, .pl_dmem_we, .pl_addr, .pl_wdata,
    .pc_o, .instr_o, .wb_en_o, .wb_addr_o, .wb_data_o,
    .dm_we_o, .dm_addr_o, .dm_wdata_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic load_word(input bit is_imem, input int idx, input logic [31:0] w);
    @(negedge clk);
    pl_imem_we = is_imem;
    pl_dmem_we = !is_imem;
    pl_addr    = MEM_AW'(idx);
    pl_wdata   = w;
    @(negedge clk);
    pl_imem_we = 1'b0;
    pl_dmem_we = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic push_exp(input logic [31:0] pc, input string pc_req,
                          input logic wb_en, input logic [4:0] wa, input logic [31:0] wd,
                          input logic dm_we, input logic [31:0] da, input logic [31:0] dd,
                          input string req);
    exp_t e;
    e.pc = pc; e.pc_req = pc_req; e.wb_en = wb_en; e.wb_addr = wa; e.wb_data = wd;
    e.dm_we = dm_we; e.dm_addr = da; e.dm_data = dd; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor side: one expected item per executed instruction
  always @(negedge clk) begin
    if (mon_on && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(pc_o === e.pc, e.pc_req, "pc", pc_o, e.pc);
      check(wb_en_o === e.wb_en, e.req, "wb_en", 32'(wb_en_o), 32'(e.wb_en));
      if (e.wb_en) begin
        check(wb_addr_o === e.wb_addr, e.req, "wb_addr", 32'(wb_addr_o), 32'(e.wb_addr));
        check(wb_data_o === e.wb_data, e.req, "wb_data", wb_data_o, e.wb_data);
      end
      check(dm_we_o === e.dm_we, e.req, "dm_we", 32'(dm_we_o), 32'(e.dm_we));
      if (e.dm_we) begin
        check(dm_addr_o === e.dm_addr, e.req, "dm_addr", dm_addr_o, e.dm_addr);
        check(dm_wdata_o === e.dm_data, e.req, "dm_wdata", dm_wdata_o, e.dm_data);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d items left", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0;
    pl_imem_we = 1'b0; pl_dmem_we = 1'b0; pl_addr = '0; pl_wdata = '0;
    repeat (3) @(negedge clk);
    check(pc_o === 32'd0, "R1", "pc in reset", pc_o, 32'd0);
    rst_n = 1'b1;

    // data words
    load_word(0, 0, 32'd5);
    load_word(0, 1, 32'd7);
    // program (byte address = 4*index)
    load_word(1, 0,  enc_i(6'h23, 5'd0, 5'd1, 16'd0));       // lw r1,0(r0)
    load_word(1, 1,  enc_i(6'h23, 5'd0, 5'd2, 16'd4));       // lw r2,4(r0)
    load_word(1, 2,  enc_r(5'd1, 5'd2, 5'd3, 6'h20));        // add r3
    load_word(1, 3,  enc_r(5'd1, 5'd2, 5'd4, 6'h22));        // sub r4
    load_word(1, 4,  enc_i(6'h2B, 5'd0, 5'd3, 16'd12));      // sw r3,12(r0)
    load_word(1, 5,  enc_i(6'h23, 5'd0, 5'd5, 16'd12));      // lw r5,12(r0)
    load_word(1, 6,  enc_r(5'd1, 5'd2, 5'd0, 6'h20));        // add r0 (dropped)
    load_word(1, 7,  enc_i(6'h2B, 5'd0, 5'd0, 16'd16));      // sw r0,16(r0)
    load_word(1, 8,  enc_i(6'h04, 5'd1, 5'd2, 16'd5));       // beq not taken
    load_word(1, 9,  enc_i(6'h04, 5'd3, 5'd5, 16'd2));       // beq taken -> 0x30
    load_word(1, 10, enc_r(5'd1, 5'd1, 5'd10, 6'h20));       // skipped
    load_word(1, 11, enc_r(5'd1, 5'd1, 5'd10, 6'h20));       // skipped
    load_word(1, 12, enc_i(6'h23, 5'd3, 5'd6, 16'hFFF8));    // lw r6,-8(r3)
    load_word(1, 13, enc_i(6'h3F, 5'd1, 5'd2, 16'd0));       // unknown opcode
    load_word(1, 14, enc_r(5'd1, 5'd2, 5'd7, 6'h25));        // unknown function
    load_word(1, 15, {6'h02, 26'h12});                       // j 0x48
    load_word(1, 16, enc_r(5'd1, 5'd1, 5'd11, 6'h20));       // skipped
    load_word(1, 17, enc_r(5'd1, 5'd1, 5'd11, 6'h20));       // skipped
    load_word(1, 18, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));    // beq r0,r0,-1 (self loop)

    // R1: held core does not move or write
    repeat (3) @(negedge clk);
    check(pc_o === 32'd0, "R1", "pc held", pc_o, 32'd0);
    check(wb_en_o === 1'b0, "R1", "wb_en held", 32'(wb_en_o), 32'd0);
    check(dm_we_o === 1'b0, "R1", "dm_we held", 32'(dm_we_o), 32'd0);

    push_exp(32'h00, "R1", 1, 5'd1, 32'd5,  0, 0, 0, "R4");
    push_exp(32'h04, "R2", 1, 5'd2, 32'd7,  0, 0, 0, "R4");
    push_exp(32'h08, "R2", 1, 5'd3, 32'd12, 0, 0, 0, "R3");
    push_exp(32'h0C, "R2", 1, 5'd4, 32'hFFFF_FFFE, 0, 0, 0, "R3");
    push_exp(32'h10, "R2", 0, 0, 0, 1, 32'd12, 32'd12, "R5");
    push_exp(32'h14, "R2", 1, 5'd5, 32'd12, 0, 0, 0, "R5");
    push_exp(32'h18, "R2", 0, 0, 0, 0, 0, 0, "R8");
    push_exp(32'h1C, "R2", 0, 0, 0, 1, 32'd16, 32'd0, "R8");
    push_exp(32'h20, "R2", 0, 0, 0, 0, 0, 0, "R6");
    push_exp(32'h24, "R6", 0, 0, 0, 0, 0, 0, "R6");
    push_exp(32'h30, "R6", 1, 5'd6, 32'd7, 0, 0, 0, "R4");
    push_exp(32'h34, "R2", 0, 0, 0, 0, 0, 0, "R9");
    push_exp(32'h38, "R9", 0, 0, 0, 0, 0, 0, "R3");
    push_exp(32'h3C, "R2", 0, 0, 0, 0, 0, 0, "R7");
    push_exp(32'h48, "R7", 0, 0, 0, 0, 0, 0, "R6");
    push_exp(32'h48, "R6", 0, 0, 0, 0, 0, 0, "R6");
    push_exp(32'h48, "R6", 0, 0, 0, 0, 0, 0, "R6");

    @(posedge clk);
    #1;
    run    = 1'b1;
    mon_on = 1'b1;
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    #1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule